// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM and Interval Timer

This block is one up-counter of configurable width, 8 bits by default, that works in one of two modes. In interval mode it counts count-clock ticks up to a compare value. On the tick that finds the counter equal to that value, it sets an interrupt flag, restarts from zero and toggles a square-wave output. In PWM mode the counter runs freely through its full range. The output is high while the count is below a duty value, which gives a pulse-width-modulated wave whose period is 256 ticks.

The count clock comes from one of two places. The first is an internal prescaler on the system clock that divides by 4, 32, 64 or 256; at 10 MHz these are ticks of 0.4, 3.2, 6.4 and 25.6 us. The second is a single-cycle tick from a neighbouring 8-bit timer or a neighbouring 16-bit timer. Software sets the block up through a small write port that has a control register and a compare/duty register. A compare or duty value written while the timer runs is held in a buffer. It takes effect only at the next period boundary.

Top module: `pwm_interval_timer`

## Requirements
- R1: After reset, `wave_o` and `irq_o` are low, and the timer is stopped in interval mode with the prescaler divide-by-4 source selected.
- R2: In interval mode with compare value C (address 1), the interrupt flag `irq_o` sets on the (C+1)-th count tick after start or after the previous match, and the counter restarts from zero on that tick.
- R3: In interval mode, `wave_o` toggles on every match tick and on no other tick; it starts low.
- R4: Once set, the interrupt flag stays set until a control write (address 0) with bit 7 at 1. If a match and such a clearing write fall in the same cycle, the flag ends set.
- R5: In PWM mode with duty D, `wave_o` is high exactly while the counter value is below D. A duty of 0 gives a constant low output, and a duty of 255 gives low for one tick per period.
- R6: In PWM mode the counter wraps from 255 to 0, so one period is 256 count ticks.
- R7: A compare or duty value written while running is buffered. It takes effect on the first match (interval) or wrap (PWM) after the write. While the timer is stopped, the buffered value is taken over at once.
- R8: With control bit 0 (run) at 0, the counter is held at zero, `wave_o` is low, and count ticks are ignored. The interrupt flag keeps its value.
- R9: With control bit 4 at 0, control bits 3:2 select the prescaler divide ratio: 0 gives 4, 1 gives 32, 2 gives 64 and 3 gives 256 system clocks per tick. The divider is held at zero while stopped. In PWM mode with divide-by-4, the period is 1024 system clocks.
- R10: With control bit 4 at 1, counting uses `ext8_tick_i` when control bit 5 is 0, or `ext16_tick_i` when bit 5 is 1. The unselected tick input has no effect. Control bit 1 selects PWM mode when 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: control register, 1: compare/duty register |
| wr_data_i | input | WIDTH | Write data |
| ext8_tick_i | input | 1 | Count enable from the neighbouring 8-bit timer |
| ext16_tick_i | input | 1 | Count enable from the neighbouring 16-bit timer |
| wave_o | output | 1 | Square-wave or PWM output |
| irq_o | output | 1 | Interrupt request (the interval match flag) |

## Verification
Two functions can fall in the same cycle: a compare match setting the interrupt flag and a control write clearing it. The bench provokes this by raising the external tick and the clearing write on the same clock edge, while the counter already equals the compare value. It then requires the flag to be set and the square wave to have toggled. A second collision, a compare write landing mid-period, is judged by showing that the old value still sets the end of the current period.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic {
      MODE_INTERVAL = 1'b0,
      MODE_PWM      = 1'b1
   } pit_mode_e;

   // Control register image, bit 0 at the bottom
   typedef struct packed {
      logic      ext_is_16;   // bit 5
      logic      use_ext;     // bit 4
      logic [1:0] presel;     // bits 3:2
      pit_mode_e mode;        // bit 1
      logic      run;         // bit 0
   } pit_ctrl_t;

   localparam int unsigned CTRL_BITS    = $bits(pit_ctrl_t);
   localparam int unsigned CTRL_CLR_POS = 7;
   localparam logic        ADDR_CTRL    = 1'b0;
   localparam logic        ADDR_DATA    = 1'b1;

endpackage

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_addr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output pit_ctrl_t        ctrl_o,
   output logic [WIDTH-1:0] data_buf_o,
   output logic             clr_o
);

   pit_ctrl_t        ctrl_q;
   logic [WIDTH-1:0] buf_q;
   logic             wr_ctrl;
   logic             wr_data;
   logic             unused_bits;

   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
   assign wr_data = wr_en_i && (wr_addr_i == ADDR_DATA);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         buf_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= pit_ctrl_t'(wr_data_i[CTRL_BITS-1:0]);
         if (wr_data) buf_q  <= wr_data_i;
      end
   end

   assign clr_o       = wr_ctrl && wr_data_i[CTRL_CLR_POS];
   assign ctrl_o      = ctrl_q;
   assign data_buf_o  = buf_q;
   assign unused_bits = wr_data_i[6] ^ (|(wr_data_i >> 8));

endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter logic [3:0][3:0] DIV_LOG2 = {4'd8, 4'd6, 4'd5, 4'd2}
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       run_i,
   input  logic [1:0] sel_i,
   output logic       tick_o
);

   localparam int unsigned NUM_SEL = 4;

   function automatic int unsigned widest(input logic [3:0][3:0] v);
      int unsigned m = 1;
      for (int i = 0; i < NUM_SEL; i++) if (int'(v[i]) > m) m = v[i];
      return m;
   endfunction

   localparam int unsigned CNT_W = widest(DIV_LOG2);

   initial begin
      for (int i = 0; i < NUM_SEL; i++)
         if (DIV_LOG2[i] == 0) $fatal(1, "divide exponent must be at least 1");
   end

   logic [CNT_W-1:0]   div_q;
   logic [NUM_SEL-1:0] taps;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     div_q <= '0;
      else if (run_i)  div_q <= div_q + 1'b1;
      else             div_q <= '0;
   end

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
      localparam int unsigned L = DIV_LOG2[g];
      assign taps[g] = &div_q[L-1:0];
   end

   assign tick_o = run_i && taps[sel_i];

   // R9: every tap includes bit 0, so two ticks are never adjacent
   a_r9_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

endmodule

// File: rtl/pit_clk_sel.sv
module pit_clk_sel #(
   parameter bit EXT_CLK_EN = 1'b1
) (
   input  logic run_i,
   input  logic use_ext_i,
   input  logic ext_is_16_i,
   input  logic pre_tick_i,
   input  logic ext8_tick_i,
   input  logic ext16_tick_i,
   output logic tick_o
);

   logic ext_tick;

   if (EXT_CLK_EN) begin : g_ext
      assign ext_tick = ext_is_16_i ? ext16_tick_i : ext8_tick_i;
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext16_tick_i ^ ext8_tick_i ^ ext_is_16_i;
      assign ext_tick   = 1'b0;
   end

   assign tick_o = run_i && (use_ext_i ? ext_tick : pre_tick_i);

endmodule

// File: rtl/pit_core.sv
module pit_core
   import pit_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  pit_mode_e        mode_i,
   input  logic             tick_i,
   input  logic [WIDTH-1:0] data_buf_i,
   input  logic             clr_i,
   output logic             wave_o,
   output logic             irq_o
);

   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] act_q;
   logic             tgl_q;
   logic             flag_q;
   logic             match;
   logic             wrap;
   logic             boundary;
   logic             pwm_level;

   assign match    = tick_i && (mode_i == MODE_INTERVAL) && (cnt_q == act_q);
   assign wrap     = tick_i && (mode_i == MODE_PWM) && (cnt_q == CNT_MAX);
   assign boundary = match || wrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         act_q <= '0;
         tgl_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         act_q <= data_buf_i;
         tgl_q <= 1'b0;
      end else if (tick_i) begin
         if (match) begin
            cnt_q <= '0;
            tgl_q <= ~tgl_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (boundary) act_q <= data_buf_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_q <= 1'b0;
      else if (match) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign pwm_level = cnt_q < act_q;
   assign wave_o    = run_i && ((mode_i == MODE_PWM) ? pwm_level : tgl_q);
   assign irq_o     = flag_q;

   // R2: a match restarts the count and raises the flag
   a_r2_match_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match |=> (cnt_q == '0) && flag_q);
   // R3: square wave toggles on a match and holds otherwise
   a_r3_toggle_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match |=> (tgl_q != $past(tgl_q)));
   a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !match) |=> $stable(tgl_q));
   // R4: flag persistence and set-over-clear priority
   a_r4_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i) |=> flag_q);
   a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match && clr_i) |=> flag_q);
   a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !match) |=> !flag_q);
   // R5: zero duty keeps the output low
   a_r5_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == MODE_PWM) && (act_q == '0)) |-> !wave_o);
   // R6: full-range wrap in PWM mode
   a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap |=> (cnt_q == '0));
   // R7: the active value moves only at a boundary while running
   a_r7_reload_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !boundary) |=> $stable(act_q));
   // R8: stopped state
   a_r8_stopped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (cnt_q == '0) && !tgl_q);
   a_r8_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> !wave_o);

endmodule

// File: rtl/pwm_interval_timer.sv
module pwm_interval_timer
   import pit_pkg::*;
#(
   parameter int unsigned     WIDTH      = 8,
   parameter logic [3:0][3:0] DIV_LOG2   = {4'd8, 4'd6, 4'd5, 4'd2},
   parameter bit              EXT_CLK_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_addr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic             ext8_tick_i,
   input  logic             ext16_tick_i,
   output logic             wave_o,
   output logic             irq_o
);

   initial begin
      if (WIDTH < 8) $fatal(1, "WIDTH must hold the control register");
   end

   pit_ctrl_t        ctrl;
   logic [WIDTH-1:0] data_buf;
   logic             clr;
   logic             pre_tick;
   logic             tick;

   pit_regs #(.WIDTH(WIDTH)) regs_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .ctrl_o     (ctrl),
      .data_buf_o (data_buf),
      .clr_o      (clr)
   );

   pit_prescaler #(.DIV_LOG2(DIV_LOG2)) presc_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (ctrl.run && !ctrl.use_ext),
      .sel_i  (ctrl.presel),
      .tick_o (pre_tick)
   );

   pit_clk_sel #(.EXT_CLK_EN(EXT_CLK_EN)) sel_i (
      .run_i        (ctrl.run),
      .use_ext_i    (ctrl.use_ext),
      .ext_is_16_i  (ctrl.ext_is_16),
      .pre_tick_i   (pre_tick),
      .ext8_tick_i  (ext8_tick_i),
      .ext16_tick_i (ext16_tick_i),
      .tick_o       (tick)
   );

   pit_core #(.WIDTH(WIDTH)) core_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (ctrl.run),
      .mode_i     (ctrl.mode),
      .tick_i     (tick),
      .data_buf_i (data_buf),
      .clr_i      (clr),
      .wave_o     (wave_o),
      .irq_o      (irq_o)
   );

   // R8 / R10: no output activity can start while stopped
   a_r8_irq_stable_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl.run && !clr) |=> $stable(irq_o));

endmodule

// File: tb/pwm_interval_timer_tb_top.sv
module pwm_interval_timer_tb_top;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       wr_en_i = 1'b0;
   logic       wr_addr_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       ext8_tick_i = 1'b0;
   logic       ext16_tick_i = 1'b0;
   logic       wave_o;
   logic       irq_o;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   localparam logic [7:0] C_RUN   = 8'h01;
   localparam logic [7:0] C_PWM   = 8'h02;
   localparam logic [7:0] C_EXT   = 8'h10;
   localparam logic [7:0] C_EXT16 = 8'h20;
   localparam logic [7:0] C_CLR   = 8'h80;

   always #5 clk_i = ~clk_i;

   pwm_interval_timer dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_en_i      (wr_en_i),
      .wr_addr_i    (wr_addr_i),
      .wr_data_i    (wr_data_i),
      .ext8_tick_i  (ext8_tick_i),
      .ext16_tick_i (ext16_tick_i),
      .wave_o       (wave_o),
      .irq_o        (irq_o)
   );

   always @(posedge clk_i) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         fails++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk_i);
      wr_en_i = 1'b0;
   endtask

   task automatic p8(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk_i); ext8_tick_i = 1'b1;
         @(negedge clk_i); ext8_tick_i = 1'b0;
      end
   endtask

   task automatic p16(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk_i); ext16_tick_i = 1'b1;
         @(negedge clk_i); ext16_tick_i = 1'b0;
      end
   endtask

   task automatic setup(input logic [7:0] val, input logic [7:0] ctl);
      wr(1'b0, C_CLR);
      wr(1'b1, val);
      wr(1'b0, ctl);
   endtask

   // cycles until wave_o changes, sampled at falling edges
   task automatic until_change(output int n);
      logic last = wave_o;
      n = 0;
      while (wave_o == last && n < 5000) begin
         @(negedge clk_i); n++;
      end
   endtask

   initial begin
      int n;
      int cs [11] = '{0, 1, 2, 3, 4, 5, 7, 10, 15, 100, 255};
      int ds [8]  = '{0, 1, 2, 3, 127, 128, 254, 255};
      int dv [4]  = '{4, 32, 64, 256};

      repeat (3) @(negedge clk_i);
      chk("R1 wave after reset", wave_o, 0);
      chk("R1 irq after reset", irq_o, 0);
      rst_ni = 1'b1;
      p8(3);
      chk("R1 stopped ignores ticks", wave_o, 0);
      chk("R1 no irq while stopped", irq_o, 0);

      // interval sweep on the 8-bit external tick
      foreach (cs[i]) begin
         setup(8'(cs[i]), C_RUN | C_EXT);
         p8(cs[i]);
         chk("R2 no irq before C+1 ticks", irq_o, 0);
         chk("R3 wave low before first match", wave_o, 0);
         p8(1);
         chk("R2 irq at C+1 ticks", irq_o, 1);
         chk("R3 wave toggled high", wave_o, 1);
         p8(cs[i]);
         chk("R4 flag held without clear", irq_o, 1);
         chk("R3 wave holds between matches", wave_o, 1);
         wr(1'b0, C_CLR | C_RUN | C_EXT);
         chk("R4 flag cleared by write", irq_o, 0);
         p8(1);
         chk("R2 restart gives period C+1", irq_o, 1);
         chk("R3 wave toggled low", wave_o, 0);
      end

      // match and clear in the same cycle: set wins
      setup(8'd3, C_RUN | C_EXT);
      p8(3);
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = C_CLR | C_RUN | C_EXT;
      ext8_tick_i = 1'b1;
      @(negedge clk_i);
      wr_en_i = 1'b0; ext8_tick_i = 1'b0;
      chk("R4 set wins over clear", irq_o, 1);
      chk("R3 wave toggled on colliding match", wave_o, 1);

      // buffered compare
      wr(1'b0, 8'h00);
      setup(8'd9, C_RUN | C_EXT);
      p8(3);
      wr(1'b1, 8'd2);
      p8(6);
      chk("R7 old compare still active", irq_o, 0);
      p8(1);
      chk("R7 period ends on old compare", irq_o, 1);
      wr(1'b0, C_CLR | C_RUN | C_EXT);
      p8(2);
      chk("R7 new compare not yet reached", irq_o, 0);
      p8(1);
      chk("R7 new compare used next period", irq_o, 1);

      // stop behaviour: wave is high here (two matches -> low, check state first)
      p8(3);
      chk("R8 wave high before stop", wave_o, 1);
      wr(1'b0, 8'h00 | C_EXT);
      chk("R8 wave low when stopped", wave_o, 0);
      chk("R8 flag kept when stopped", irq_o, 1);
      p8(5);
      chk("R8 ticks ignored while stopped", wave_o, 0);
      wr(1'b0, C_CLR | C_EXT);
      wr(1'b0, C_RUN | C_EXT);
      p8(2);
      chk("R8 counter held at zero", irq_o, 0);
      p8(1);
      chk("R8 count resumed from zero", irq_o, 1);

      // external source select
      wr(1'b0, 8'h00);
      setup(8'd1, C_RUN | C_EXT | C_EXT16);
      p8(4);
      chk("R10 ext8 ignored when ext16 selected", irq_o, 0);
      p16(2);
      chk("R10 ext16 counts", irq_o, 1);
      wr(1'b0, 8'h00);
      setup(8'd1, C_RUN | C_EXT);
      p16(4);
      chk("R10 ext16 ignored when ext8 selected", irq_o, 0);

      // PWM duty sweep: wave == (count < D)
      foreach (ds[i]) begin
         int bad = 0;
         wr(1'b0, 8'h00);
         setup(8'(ds[i]), C_RUN | C_PWM | C_EXT);
         for (int k = 0; k < 256; k++) begin
            if (wave_o != (k < ds[i])) bad++;
            p8(1);
         end
         chk("R5 duty compare over a period", bad, 0);
         chk("R6 wrap after 256 ticks", wave_o, (ds[i] > 0) ? 1 : 0);
      end

      // buffered duty
      begin
         int bad = 0;
         wr(1'b0, 8'h00);
         setup(8'd200, C_RUN | C_PWM | C_EXT);
         p8(10);
         wr(1'b1, 8'd20);
         for (int k = 10; k < 256; k++) begin
            if (wave_o != (k < 200)) bad++;
            p8(1);
         end
         chk("R7 old duty kept to period end", bad, 0);
         bad = 0;
         for (int k = 0; k < 256; k++) begin
            if (wave_o != (k < 20)) bad++;
            p8(1);
         end
         chk("R7 new duty after wrap", bad, 0);
      end

      // prescaler ratios in interval mode, compare 3
      foreach (dv[s]) begin
         wr(1'b0, 8'h00);
         setup(8'd3, C_RUN | 8'(s << 2));
         until_change(n);
         until_change(n);
         chk("R9 toggle spacing = div*(C+1)", n, dv[s] * 4);
      end

      // shortest PWM period: divide-by-4, duty 64
      wr(1'b0, 8'h00);
      setup(8'd64, C_RUN | C_PWM);
      until_change(n);
      if (wave_o == 1'b0) until_change(n);
      until_change(n);
      chk("R9 PWM high time 64 ticks of 4", n, 256);
      until_change(n);
      chk("R9 PWM low time 192 ticks of 4", n, 768);

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule